// File: doc/BRIEF.md
# General-Purpose I/O Port with Atomic Bit Operations

This block drives and samples a port of up to 32 general-purpose pins. It sits on a simple memory-mapped register bus: a select, a write enable, a word index, write data and combinational read data. Software controls the pins through an output latch and a per-pin direction register. Three alias locations are write-only. Writing a mask to one of them sets, clears or inverts the chosen latch bits in a single bus cycle, so no read-modify-write sequence is needed.

Each pin's level first passes through one synchronizer flop. It is then captured into a read-only input register, which serves as the second synchronizer stage. Capture is gated two ways. A per-pin digital-function flag forces the captured bit to zero. A port-control enable, while low, freezes the whole input register. A parameter marks which pins exist, and bits of pins that do not exist read zero everywhere.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch, the direction register and the input register are all zero, and so are pin_out and pin_oe.
- R2: Word index 0 is the output latch. A write stores bus_wdata on the clock edge, a read returns the stored value, and pin_out shows the latch from the cycle after the write.
- R3: Writing word index 1 drives to 1 every latch bit whose write-data bit is 1, and leaves the other latch bits as they were.
- R4: Writing word index 2 drives to 0 every latch bit whose write-data bit is 1, and leaves the other latch bits as they were.
- R5: Writing word index 3 inverts every latch bit whose write-data bit is 1, and leaves the other latch bits as they were.
- R6: A read of word index 1, 2 or 3 returns zero.
- R7: Word index 5 is the direction register and can be read and written. A 1 bit makes that pin an output (pin_oe high) and a 0 bit makes it an input.
- R8: A read of word index 4 returns the level that pin_in had before the last two rising clock edges: one synchronizer flop, then the input register.
- R9: A bit whose pin_digital flag is 0 at the capture edge is stored as 0 in the input register.
- R10: While port_en is 0 at a clock edge, the input register keeps its value.
- R11: Writes to word index 4, 6 or 7 change no state. Reads of index 6 or 7 return zero, and bus_rdata is zero whenever no read is selected.
- R12: Pins whose bit is 0 in the IMPL_MASK parameter (default 0x7FFF_FFFF, so bit 31 is absent) read 0 in every register and keep pin_out and pin_oe at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access selected this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| port_en | input | 1 | Port-control enable; 0 freezes input capture |
| pin_digital | input | 32 | Per-pin flag: pin is in digital function |
| pin_in | input | 32 | External pin levels |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Output enable per pin |

## Verification
A wrong latch or direction bit shows on pin_out or pin_oe at the first negative edge after the faulty clock edge. The bench compares both outputs with its model every cycle, so a bad set, clear or toggle update is caught one cycle after the write. A fault in the input path, whether from capture gating, freezing or latency, stays hidden until index 4 is read. The bench therefore reads that index often and at fixed delays after pin changes, so a one-cycle skew or a missed freeze shows in the next read. A nonzero value leaking from an alias, an unmapped index or an absent pin shows at once in the combinational read data of the same cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Word indices of the register map
    typedef enum logic [2:0] {
        IDX_LATCH  = 3'd0,
        IDX_SET    = 3'd1,
        IDX_CLR    = 3'd2,
        IDX_TOG    = 3'd3,
        IDX_INPUT  = 3'd4,
        IDX_DIR    = 3'd5,
        IDX_FREE6  = 3'd6,
        IDX_FREE7  = 3'd7
    } reg_idx_e;

    localparam int IDX_W = 3;

    // One write strobe per writable register
    typedef struct packed {
        logic latch;
        logic set;
        logic clr;
        logic tog;
        logic dir;
    } wr_strobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stg_d[g] = async_in;
        end else begin : g_next
            always_comb stg_d[g] = stg_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[g] <= '0;
            else        stg_q[g] <= stg_d[g];
        end
    end

    assign sync_out = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_in_reg.sv
module gpio_in_reg #(
    parameter int           W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         port_en,
    input  logic [W-1:0] pin_digital,
    input  logic [W-1:0] sync_in,
    output logic [W-1:0] in_q
);
    logic [W-1:0] in_d;

    always_comb begin
        in_d = in_q;
        if (port_en) in_d = sync_in & pin_digital & IMPL_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    AST_FROZEN_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> $stable(in_q)); // R10
    AST_NONDIGITAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |=> ((in_q & ~$past(pin_digital)) == '0)); // R9
endmodule

// File: rtl/gpio_out_regs.sv
module gpio_out_regs
    import gpio_pkg::*;
#(
    parameter int           W         = 32,
    parameter logic [W-1:0] IMPL_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strobe_t   strb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } out_state_t;

    out_state_t   st_d, st_q;
    logic [W-1:0] wm;

    always_comb begin
        wm   = wdata & IMPL_MASK;
        st_d = st_q;
        if (strb.latch) st_d.latch = wm;
        if (strb.set)   st_d.latch = st_q.latch | wm;
        if (strb.clr)   st_d.latch = st_q.latch & ~wm;
        if (strb.tog)   st_d.latch = st_q.latch ^ wm;
        if (strb.dir)   st_d.dir   = wm;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch_q = st_q.latch;
    assign dir_q   = st_q.dir;

    AST_SET_BITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        strb.set |=> ((latch_q & $past(wm)) == $past(wm))); // R3
    AST_CLR_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        strb.clr |=> ((latch_q & $past(wm)) == '0)); // R4
    AST_TOG_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        strb.tog |=> (latch_q == ($past(latch_q) ^ $past(wm)))); // R5
    AST_ABSENT_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((latch_q | dir_q) & ~IMPL_MASK) == '0); // R12
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int           W         = 32,
    parameter logic [W-1:0] IMPL_MASK = 32'h7FFF_FFFF,
    parameter int           SYNC_PRE  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    input  logic             port_en,
    input  logic [W-1:0]     pin_digital,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);
    wr_strobe_t   strb;
    reg_idx_e     idx;
    logic         do_wr;
    logic         do_rd;
    logic [W-1:0] latch_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] in_q;

    assign idx   = reg_idx_e'(bus_addr);
    assign do_wr = bus_sel && bus_wr;
    assign do_rd = bus_sel && !bus_wr;

    always_comb begin
        strb       = '0;
        strb.latch = do_wr && (idx == IDX_LATCH);
        strb.set   = do_wr && (idx == IDX_SET);
        strb.clr   = do_wr && (idx == IDX_CLR);
        strb.tog   = do_wr && (idx == IDX_TOG);
        strb.dir   = do_wr && (idx == IDX_DIR);
    end

    gpio_out_regs #(.W(W), .IMPL_MASK(IMPL_MASK)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_PRE)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_q)
    );

    gpio_in_reg #(.W(W), .IMPL_MASK(IMPL_MASK)) u_in (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .pin_digital (pin_digital),
        .sync_in     (sync_q),
        .in_q        (in_q)
    );

    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            case (idx)
                IDX_LATCH: bus_rdata = latch_q;
                IDX_INPUT: bus_rdata = in_q;
                IDX_DIR:   bus_rdata = dir_q;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;

    AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && (idx == IDX_SET || idx == IDX_CLR || idx == IDX_TOG)) |-> (bus_rdata == '0)); // R6
    AST_FREE_SLOT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && (idx == IDX_FREE6 || idx == IDX_FREE7)) |-> (bus_rdata == '0)); // R11
    AST_INPUT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && idx == IDX_INPUT) |=> ($stable(latch_q) && $stable(dir_q))); // R11
    AST_READ_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~IMPL_MASK) == '0); // R12
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam logic [31:0] M = 32'h7FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        port_en = 1'b1;
    logic [31:0] pin_digital = '1;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [31:0] m_out = '0, m_dir = '0, m_in = '0, m_s1 = '0;

    always #10 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_en(port_en), .pin_digital(pin_digital), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic s, input logic w, input logic [2:0] a);
        if (!s || w) return 32'h0;
        case (a)
            3'd0: return m_out;
            3'd4: return m_in;
            3'd5: return m_dir;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1, 3'd2, 3'd3: return "R6";
            3'd4: return "R8";
            3'd5: return "R7";
            default: return "R11";
        endcase
    endfunction

    // One bus cycle: drive at negedge, check read data, clock, check pins
    task automatic step(input logic s, input logic w, input logic [2:0] a,
                        input logic [31:0] wd, input logic [31:0] pin,
                        input logic [31:0] dig, input logic en, input string tag = "");
        string t;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
        pin_in = pin; pin_digital = dig; port_en = en;
        #2;
        t = (tag != "") ? tag : (s && !w) ? tag_of(a) : "R11";
        chk(t, "rdata", bus_rdata, model_read(s, w, a));
        @(posedge clk);
        if (s && w) begin
            case (a)
                3'd0: m_out = wd & M;
                3'd1: m_out = m_out | (wd & M);
                3'd2: m_out = m_out & ~(wd & M);
                3'd3: m_out = m_out ^ (wd & M);
                3'd5: m_dir = wd & M;
                default: ;
            endcase
        end
        if (en) m_in = m_s1 & dig & M;
        m_s1 = pin;
        @(negedge clk);
        chk((tag != "") ? tag : "R2", "pin_out", pin_out, m_out);
        chk((tag != "") ? tag : "R7", "pin_oe", pin_oe, m_dir);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1'b1, 1'b0, a, 32'h0, pin_in, pin_digital, port_en, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        step(1'b1, 1'b1, a, d, pin_in, pin_digital, port_en, tag);
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "pin_out", pin_out, 32'h0);
        chk("R1", "pin_oe", pin_oe, 32'h0);
        for (int a = 0; a < 8; a++) rd(a[2:0], "R1");

        // R2 latch write/read, R7 direction
        wr(3'd0, 32'hA5A5_1234, "R2");
        rd(3'd0, "R2");
        wr(3'd5, 32'hFFFF_00FF, "R7");
        rd(3'd5, "R7");
        // R3 set, R4 clear, R5 toggle
        wr(3'd1, 32'h0F0F_0001, "R3");
        rd(3'd0, "R3");
        wr(3'd2, 32'hF000_1000, "R4");
        rd(3'd0, "R4");
        wr(3'd3, 32'hFFFF_0000, "R5");
        rd(3'd0, "R5");
        wr(3'd3, 32'h0, "R5");
        rd(3'd0, "R5");
        // R6 alias reads
        rd(3'd1, "R6"); rd(3'd2, "R6"); rd(3'd3, "R6");
        // R11 ignored writes and free slots
        wr(3'd4, 32'hFFFF_FFFF, "R11");
        wr(3'd6, 32'hFFFF_FFFF, "R11");
        wr(3'd7, 32'h1234_5678, "R11");
        rd(3'd6, "R11"); rd(3'd7, "R11"); rd(3'd4, "R11");
        // R12 absent pin stays low
        wr(3'd0, 32'hFFFF_FFFF, "R12");
        wr(3'd5, 32'hFFFF_FFFF, "R12");
        wr(3'd3, 32'h8000_0000, "R12");
        rd(3'd0, "R12"); rd(3'd5, "R12");

        // R8 latency: pin changes, visible after two edges
        step(1'b1, 1'b0, 3'd4, 0, 32'hDEAD_BEEF, '1, 1'b1, "R8");
        step(1'b1, 1'b0, 3'd4, 0, 32'hDEAD_BEEF, '1, 1'b1, "R8");
        step(1'b1, 1'b0, 3'd4, 0, 32'hDEAD_BEEF, '1, 1'b1, "R8");
        chk("R8", "rdata after two edges", bus_rdata, 32'h5EAD_BEEF);
        // R9 non-digital pins capture zero
        step(1'b1, 1'b0, 3'd4, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1, "R9");
        step(1'b1, 1'b0, 3'd4, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1, "R9");
        step(1'b1, 1'b0, 3'd4, 0, 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1, "R9");
        // R10 freeze while port_en low
        for (int i = 0; i < 4; i++)
            step(1'b1, 1'b0, 3'd4, 0, 32'h1357_9BDF ^ i, '1, 1'b0, "R10");
        step(1'b1, 1'b0, 3'd4, 0, 32'h1357_9BDF, '1, 1'b1, "R10");
        step(1'b1, 1'b0, 3'd4, 0, 32'h1357_9BDF, '1, 1'b1, "R10");

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 5) != 0, $urandom % 2, 3'($urandom % 8), $urandom,
                 (($urandom % 4) == 0) ? $urandom : pin_in,
                 (($urandom % 8) == 0) ? $urandom : pin_digital,
                 ($urandom % 6) != 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule